// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher with Repeat Counter

This block is the alarm section of a real-time clock. An external timekeeping counter supplies the current time and date as BCD fields, a flag that marks which half of the current second is running, and a strobe that pulses once per half second. On each strobe, the block compares the stored alarm fields against the current time. A mask code selects which fields take part in the comparison. When the fields match and the alarm is armed, the block raises a one-clock alarm pulse.

Software controls the block through two register ports. A 16-bit configuration word holds the arm bit, the chime bit, the mask code, a window pointer and an 8-bit repeat count. The alarm fields are stored in words that all share one data port. The window pointer picks which word that port reads or writes, and it steps down by one after every access.

The repeat count decreases by one on each alarm event. With chime cleared, the count stops at zero and the alarm disarms itself. With chime set, the count wraps from zero to 0xFF, so the alarm repeats indefinitely.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, the configuration word reads 0x0000, every alarm word reads 0x0000 and the alarm pulse is low.
- R2: Configuration bit layout: bit 15 arm, bit 14 chime, bits 13:10 mask code, bits 9:8 window pointer, bits 7:0 repeat count. A written value reads back unchanged until the block itself updates a field.
- R3: Window pointer selection: pointer 0 selects {minutes[15:8], seconds[7:0]}, pointer 1 selects {weekday[15:8], hours[7:0]} and pointer 2 selects {month[15:8], day[7:0]}. Pointer 3 reads as zero and ignores writes. Every read strobe or write strobe on the shared port lowers the pointer by one after the access, and the pointer stays at 0 once it gets there.
- R4: Matching happens only while the half-second strobe is high. The alarm pulse goes high in the clock cycle after that strobe and lasts exactly one cycle.
- R5: Mask codes select the compared fields. 0: every strobe. 1: each strobe with the half flag at 0 (a second boundary). Codes 2 through 9 also require the half flag at 0, plus these fields: 2, the seconds low digit; 3, the seconds; 4, seconds and the minutes low digit; 5, seconds and minutes; 6, seconds, minutes and hours; 7, code 6 plus weekday; 8, code 6 plus day; 9, code 8 plus month. An alarm set for February 29 in code 9 fires only on dates that carry that day.
- R6: Mask codes 10 through 15 never produce an alarm pulse and leave the repeat count and the arm bit unchanged.
- R7: Each alarm event with a nonzero repeat count lowers the count by one.
- R8: An alarm event with count 0 and chime set loads the count with 0xFF and keeps the alarm armed.
- R9: An alarm event with count 0 and chime cleared clears the arm bit and leaves the count at 0.
- R10: A configuration write in the same cycle as an alarm event wins: the written word is stored unchanged. The pulse for that event still depends on the configuration held before the write.
- R11: While the arm bit is 0, no alarm pulse occurs, even when the fields match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| halfTick | input | 1 | Half-second strobe from the timekeeping counter |
| curHalf | input | 1 | 0 in the first half of a second, 1 in the second half |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curWday | input | 8 | Current weekday |
| curDay | input | 8 | Current day of month, BCD |
| curMonth | input | 8 | Current month, BCD |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 16 | Configuration write data |
| cfgRdData | output | 16 | Configuration read data |
| valWrEn | input | 1 | Alarm word write strobe (steps the pointer) |
| valRdEn | input | 1 | Alarm word read strobe (steps the pointer) |
| valWrData | input | 16 | Alarm word write data |
| valRdData | output | 16 | Alarm word selected by the pointer |
| alarmPulse | output | 1 | One-cycle alarm event |

## Verification
Assertions inside the control and datapath modules check a set of rules on every cycle:
- every pulse follows a strobe taken while the alarm was armed;
- reserved codes stay silent;
- the repeat count decreases, wraps or disarms the alarm exactly as R7 to R9 require;
- a configuration write always wins over an event in the same cycle;
- the pointer never goes below zero.

Three behaviours can only be shown by the bench's scenarios:
- which fields each mask code compares, including the February 29 case;
- the pointer-to-word mapping and the ignored fourth word;
- the full countdown that ends in self-disarm.

A bench model predicts these from random times, masks and counts.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FieldW = 8;
  localparam int WordW  = 2 * FieldW;
  localparam int RptW   = 8;
  localparam int PtrW   = 2;
  localparam int MaskW  = 4;

  typedef enum logic [MaskW-1:0] {
    MaskHalf   = 4'd0,
    MaskSec    = 4'd1,
    MaskTenSec = 4'd2,
    MaskMin    = 4'd3,
    MaskTenMin = 4'd4,
    MaskHour   = 4'd5,
    MaskDay    = 4'd6,
    MaskWeek   = 4'd7,
    MaskMonth  = 4'd8,
    MaskYear   = 4'd9
  } maskCode_e;

  // Field order mirrors the bit positions of the configuration word.
  typedef struct packed {
    logic            en;
    logic            chime;
    logic [MaskW-1:0] mask;
    logic [PtrW-1:0]  ptr;
    logic [RptW-1:0]  rpt;
  } cfg_t;

  typedef struct packed {
    logic            valWrite;
    logic [PtrW-1:0] ptr;
  } dpStrobe_t;

  typedef struct packed {
    logic [FieldW-1:0] month;
    logic [FieldW-1:0] day;
    logic [FieldW-1:0] wday;
    logic [FieldW-1:0] hour;
    logic [FieldW-1:0] min;
    logic [FieldW-1:0] sec;
    logic              half;
  } rtcTime_t;
endpackage

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [WordW-1:0] valWrData,
  input  rtcTime_t         curTime,
  input  logic [MaskW-1:0] mask,
  output logic [WordW-1:0] valRdData,
  output logic             matchHit,
  output logic             maskValid
);
  localparam int NumWords = 3;

  logic [WordW-1:0] alWord [NumWords];

  for (genvar w = 0; w < NumWords; w++) begin : gWord
    logic [WordW-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordQ <= '0;
      else if (strobe.valWrite && strobe.ptr == PtrW'(w)) wordQ <= valWrData;
    end
    assign alWord[w] = wordQ;
  end

  always_comb begin
    case (strobe.ptr)
      PtrW'(0): valRdData = alWord[0];
      PtrW'(1): valRdData = alWord[1];
      PtrW'(2): valRdData = alWord[2];
      default:  valRdData = '0;
    endcase
  end

  logic [FieldW-1:0] alSec, alMin, alHour, alWday, alDay, alMonth;
  assign alSec   = alWord[0][FieldW-1:0];
  assign alMin   = alWord[0][WordW-1:FieldW];
  assign alHour  = alWord[1][FieldW-1:0];
  assign alWday  = alWord[1][WordW-1:FieldW];
  assign alDay   = alWord[2][FieldW-1:0];
  assign alMonth = alWord[2][WordW-1:FieldW];

  logic onSec, secLo, secEq, minLo, minEq, hourEq, wdayEq, dayEq, monEq;
  assign onSec  = !curTime.half;
  assign secLo  = curTime.sec[3:0] == alSec[3:0];
  assign secEq  = curTime.sec == alSec;
  assign minLo  = curTime.min[3:0] == alMin[3:0];
  assign minEq  = curTime.min == alMin;
  assign hourEq = curTime.hour == alHour;
  assign wdayEq = curTime.wday == alWday;
  assign dayEq  = curTime.day == alDay;
  assign monEq  = curTime.month == alMonth;

  always_comb begin
    maskValid = 1'b1;
    case (maskCode_e'(mask))
      MaskHalf:   matchHit = 1'b1;
      MaskSec:    matchHit = onSec;
      MaskTenSec: matchHit = onSec && secLo;
      MaskMin:    matchHit = onSec && secEq;
      MaskTenMin: matchHit = onSec && secEq && minLo;
      MaskHour:   matchHit = onSec && secEq && minEq;
      MaskDay:    matchHit = onSec && secEq && minEq && hourEq;
      MaskWeek:   matchHit = onSec && secEq && minEq && hourEq && wdayEq;
      MaskMonth:  matchHit = onSec && secEq && minEq && hourEq && dayEq;
      MaskYear:   matchHit = onSec && secEq && minEq && hourEq && dayEq && monEq;
      default: begin
        matchHit  = 1'b0;
        maskValid = 1'b0;
      end
    endcase
  end

  // R5: any mask coarser than every half second only matches on a second boundary
  p_boundary_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit && mask != MaskW'(0)) |-> !curTime.half);

  // R3: a write into word 0 is held there
  p_word0_store_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.valWrite && strobe.ptr == PtrW'(0)) |=> alWord[0] == $past(valWrData));
endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             cfgWrEn,
  input  logic [WordW-1:0] cfgWrData,
  input  logic             valWrEn,
  input  logic             valRdEn,
  input  logic             matchHit,
  input  logic             maskValid,
  output logic [WordW-1:0] cfgRdData,
  output logic [MaskW-1:0] mask,
  output dpStrobe_t        strobe,
  output logic             alarmPulse
);
  cfg_t cfgQ;
  logic fire, valAccess;

  assign fire      = halfTick && cfgQ.en && matchHit;
  assign valAccess = valWrEn || valRdEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (cfgWrEn) begin
      cfgQ <= cfg_t'(cfgWrData);
    end else begin
      if (valAccess && cfgQ.ptr != '0) cfgQ.ptr <= cfgQ.ptr - PtrW'(1);
      if (fire) begin
        if (cfgQ.rpt != '0) cfgQ.rpt <= cfgQ.rpt - RptW'(1);
        else if (cfgQ.chime) cfgQ.rpt <= '1;
        else cfgQ.en <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) alarmPulse <= 1'b0;
    else alarmPulse <= fire;
  end

  assign cfgRdData       = WordW'(cfgQ);
  assign mask            = cfgQ.mask;
  assign strobe.valWrite = valWrEn;
  assign strobe.ptr      = cfgQ.ptr;

  p_pulse_after_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |-> $past(halfTick));
  p_pulse_needs_arm_r11: assert property (@(posedge clk) disable iff (!rstN)
    alarmPulse |-> $past(cfgQ.en));
  p_reserved_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    (halfTick && !maskValid) |=> !alarmPulse);
  p_rpt_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !cfgWrEn && cfgQ.rpt != '0) |=> cfgQ.rpt == $past(cfgQ.rpt) - RptW'(1));
  p_rpt_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !cfgWrEn && cfgQ.rpt == '0 && cfgQ.chime) |=> (cfgQ.rpt == '1 && cfgQ.en));
  p_self_disarm_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !cfgWrEn && cfgQ.rpt == '0 && !cfgQ.chime) |=> (!cfgQ.en && cfgQ.rpt == '0));
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == $past(cfgWrData));
  p_ptr_floor_r3: assert property (@(posedge clk) disable iff (!rstN)
    (valAccess && !cfgWrEn && cfgQ.ptr == '0) |=> cfgQ.ptr == '0);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              curHalf,
  input  logic [FieldW-1:0] curSec,
  input  logic [FieldW-1:0] curMin,
  input  logic [FieldW-1:0] curHour,
  input  logic [FieldW-1:0] curWday,
  input  logic [FieldW-1:0] curDay,
  input  logic [FieldW-1:0] curMonth,
  input  logic              cfgWrEn,
  input  logic [WordW-1:0]  cfgWrData,
  output logic [WordW-1:0]  cfgRdData,
  input  logic              valWrEn,
  input  logic              valRdEn,
  input  logic [WordW-1:0]  valWrData,
  output logic [WordW-1:0]  valRdData,
  output logic              alarmPulse
);
  rtcTime_t         curTime;
  dpStrobe_t        strobe;
  logic [MaskW-1:0] mask;
  logic             matchHit, maskValid;

  assign curTime = '{month: curMonth, day: curDay, wday: curWday, hour: curHour,
                     min: curMin, sec: curSec, half: curHalf};

  rtc_alarm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .valWrEn(valWrEn), .valRdEn(valRdEn),
    .matchHit(matchHit), .maskValid(maskValid), .cfgRdData(cfgRdData),
    .mask(mask), .strobe(strobe), .alarmPulse(alarmPulse)
  );

  rtc_alarm_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .valWrData(valWrData),
    .curTime(curTime), .mask(mask), .valRdData(valRdData),
    .matchHit(matchHit), .maskValid(maskValid)
  );
endmodule

// File: tb/rtc_alarm_match_test.sv
`timescale 1ns/1ps
module rtc_alarm_match_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic halfTick = 0, curHalf = 0, cfgWrEn = 0, valWrEn = 0, valRdEn = 0;
  logic [7:0] curSec = 0, curMin = 0, curHour = 0, curWday = 0, curDay = 0, curMonth = 0;
  logic [15:0] cfgWrData = 0, valWrData = 0, cfgRdData, valRdData;
  logic alarmPulse;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] mCfg = 0;
  logic [15:0] mAl [3] = '{default: 16'h0};

  always #2 clk = ~clk;

  rtc_alarm_match uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expHit(logic [3:0] m);
    bit s0 = !curHalf;
    bit sLo = curSec[3:0] == mAl[0][3:0];
    bit sE = curSec == mAl[0][7:0];
    bit mLo = curMin[3:0] == mAl[0][11:8];
    bit mE = curMin == mAl[0][15:8];
    bit hE = curHour == mAl[1][7:0];
    bit wE = curWday == mAl[1][15:8];
    bit dE = curDay == mAl[2][7:0];
    bit moE = curMonth == mAl[2][15:8];
    case (m)
      4'd0: return 1;
      4'd1: return s0;
      4'd2: return s0 & sLo;
      4'd3: return s0 & sE;
      4'd4: return s0 & sE & mLo;
      4'd5: return s0 & sE & mE;
      4'd6: return s0 & sE & mE & hE;
      4'd7: return s0 & sE & mE & hE & wE;
      4'd8: return s0 & sE & mE & hE & dE;
      4'd9: return s0 & sE & mE & hE & dE & moE;
      default: return 0;
    endcase
  endfunction

  function automatic void modelEvent();
    if (mCfg[7:0] != 0) mCfg[7:0] = mCfg[7:0] - 1;
    else if (mCfg[14]) mCfg[7:0] = 8'hFF;
    else mCfg[15] = 0;
  endfunction

  function automatic void stepPtr();
    if (mCfg[9:8] != 0) mCfg[9:8] = mCfg[9:8] - 1;
  endfunction

  task automatic cfgWrite(logic [15:0] d, string req);
    @(negedge clk); cfgWrEn = 1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 0; mCfg = d;
    chk(req, cfgRdData, mCfg);
  endtask

  task automatic valWrite(logic [15:0] d);
    @(negedge clk); valWrEn = 1; valWrData = d;
    if (mCfg[9:8] != 2'd3) mAl[mCfg[9:8]] = d;
    @(negedge clk); valWrEn = 0; stepPtr();
    chk("R3", cfgRdData, mCfg);
  endtask

  task automatic valRead();
    @(negedge clk);
    chk("R3", valRdData, (mCfg[9:8] == 2'd3) ? 16'h0 : mAl[mCfg[9:8]]);
    valRdEn = 1;
    @(negedge clk); valRdEn = 0; stepPtr();
    chk("R3", cfgRdData, mCfg);
  endtask

  task automatic doTick(bit withWr, logic [15:0] wd, string req);
    bit e;
    @(negedge clk);
    halfTick = 1;
    if (withWr) begin cfgWrEn = 1; cfgWrData = wd; end
    e = mCfg[15] && expHit(mCfg[13:10]);
    @(negedge clk);
    halfTick = 0; cfgWrEn = 0;
    chk(req, alarmPulse, e);
    if (withWr) mCfg = wd;
    else if (e) modelEvent();
    chk(req, cfgRdData, mCfg);
    @(negedge clk);
    chk("R4", alarmPulse, 0);
  endtask

  task automatic matchTime();
    curHalf = 0;
    curSec = mAl[0][7:0]; curMin = mAl[0][15:8];
    curHour = mAl[1][7:0]; curWday = mAl[1][15:8];
    curDay = mAl[2][7:0]; curMonth = mAl[2][15:8];
  endtask

  task automatic randTime();
    matchTime();
    curHalf = $urandom % 4 == 0;
    if ($urandom % 4 == 0) curSec = 8'($urandom);
    else if ($urandom % 3 == 0) curSec[7:4] = 4'($urandom);
    if ($urandom % 4 == 0) curMin = 8'($urandom);
    else if ($urandom % 3 == 0) curMin[7:4] = 4'($urandom);
    if ($urandom % 5 == 0) curHour = 8'($urandom);
    if ($urandom % 5 == 0) curWday = 8'($urandom);
    if ($urandom % 5 == 0) curDay = 8'($urandom);
    if ($urandom % 5 == 0) curMonth = 8'($urandom);
  endtask

  task automatic loadAlarm(logic [15:0] w2, logic [15:0] w1, logic [15:0] w0);
    cfgWrite(16'h0200, "R2");
    valWrite(w2); valWrite(w1); valWrite(w0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", cfgRdData, 16'h0);
    chk("R1", valRdData, 16'h0);
    chk("R1", alarmPulse, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1", cfgRdData, 16'h0);

    // R2 layout readback
    cfgWrite(16'hB6A5, "R2");
    cfgWrite(16'h0000, "R2");

    // R3 pointer window: word 3 ignores writes, saturation at 0
    cfgWrite(16'h0300, "R2");
    valWrite(16'hDEAD);
    valWrite(16'h0229); valWrite(16'h0312); valWrite(16'h4530);
    valWrite(16'h4530);
    cfgWrite(16'h0300, "R2");
    valRead(); valRead(); valRead(); valRead(); valRead();

    // R4 no pulse without a tick; R7 countdown; R9 disarm; R11 no pulse when disarmed
    cfgWrite(16'h8002, "R2");
    matchTime();
    repeat (4) begin @(negedge clk); chk("R4", alarmPulse, 0); end
    doTick(0, 0, "R7");
    doTick(0, 0, "R7");
    doTick(0, 0, "R9");
    chk("R9", cfgRdData[15], 0);
    doTick(0, 0, "R11");

    // R8 chime wrap
    cfgWrite(16'hC000, "R2");
    doTick(0, 0, "R8");
    chk("R8", cfgRdData, 16'hC0FF);

    // R6 reserved code with matching time
    cfgWrite(16'h8000 | (16'd10 << 10) | 16'h0005, "R2");
    doTick(0, 0, "R6");
    chk("R6", cfgRdData[7:0], 8'h05);
    cfgWrite(16'h8000 | (16'd15 << 10) | 16'h0005, "R2");
    doTick(0, 0, "R6");

    // R10 write wins over same-cycle event
    cfgWrite(16'h8003, "R2");
    doTick(1, 16'h8009, "R10");
    chk("R10", cfgRdData, 16'h8009);

    // R5 leap-day yearly alarm: alarm is Feb 29 12:45:30
    cfgWrite(16'h8000 | (16'd9 << 10) | 16'h0009, "R2");
    matchTime(); curDay = 8'h28;
    doTick(0, 0, "R5");
    matchTime();
    doTick(0, 0, "R5");
    matchTime(); curHalf = 1;
    doTick(0, 0, "R5");

    // R5 random masks, counts and times
    for (int i = 0; i < 400; i++) begin
      if (i % 8 == 0)
        loadAlarm({8'($urandom), 8'($urandom)}, {8'($urandom), 8'($urandom)},
                  {8'($urandom), 8'($urandom)});
      if ($urandom % 3 == 0) begin
        logic [15:0] d;
        d = {($urandom % 6) != 0 ? 1'b1 : 1'b0, 1'($urandom),
             4'($urandom % 12), 2'b00, 8'($urandom % 4)};
        cfgWrite(d, "R2");
      end
      randTime();
      doTick($urandom % 20 == 0, {1'b1, 1'b0, 4'($urandom % 10), 2'b00, 8'($urandom % 4)}, "R5");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule